// File: doc/BRIEF.md
# Programmable Vectored Interrupt Controller

This block collects up to eight level-sensitive interrupt request lines, filters them through a per-line mask and a fixed priority, and presents one request output to a processor. The processor answers with two acknowledge pulses. On the second pulse, the block drives an 8-bit vector onto its read-data bus. The vector is the programmed base plus the index of the granted line. A granted line stays in service, and it blocks itself and every line of lower priority until software writes an end-of-interrupt command.

Software reaches the block through two byte-wide register ports: a command port and a data port. After reset the block is unconfigured and raises no request. A command write with bit 4 set starts an initialization sequence. The next two data writes set the vector base and a cascade configuration byte. A third data write follows only if bit 0 of the starting command asked for it, and it selects the processor mode. Once the sequence is complete, data writes load the interrupt mask. Data reads return the mask, and command reads return the cascade byte.

Top module: `prog_int_ctrl`

## Requirements
- R1: After reset, `int_req` and `rdata_oe` are low, a data-port read returns mask 0xFF, and no request is raised until initialization is complete.
- R2: A command write with bit 4 set starts initialization. The following data writes set the vector base and then the cascade byte, plus a mode byte if bit 0 of the command was 1. A command-port read returns the stored cascade byte.
- R3: The vector for line n is base + n, modulo 256. It is driven only while the second acknowledge pulse is high, and never during the first.
- R4: After initialization, a data write loads the mask (bit n = 1 blocks line n), and a data read returns it. Starting initialization sets the mask to 0xFF.
- R5: Among pending unmasked lines, the lowest index wins.
- R6: A line in service blocks requests from itself and from all higher-index lines. A lower-index line can still be granted, which nests it.
- R7: A command write of 0x20 clears the in-service bit of the lowest-index line in service. Other command writes that have bit 4 clear have no effect.
- R8: If no line qualifies when the first acknowledge pulse arrives, the vector is base + 7 and no line enters service.
- R9: The vector is driven only when the mode byte was written with bit 0 = 1. If no mode byte was requested, or its bit 0 is 0, the second pulse leaves `rdata_oe` low.
- R10: Each request input passes through two flops. `int_req` answers a new request level after the second clock edge and not after the first.
- R11: `rdata_oe` is high only during a register read or during the second acknowledge pulse.
- R12: Restarting initialization clears every in-service bit, and no request is raised until the new sequence ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Register port select |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Register write strobe, one cycle per byte |
| rd_en | input | 1 | Register read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or vector |
| rdata_oe | output | 1 | Read-data bus enable |
| irq_in | input | 8 | Level-sensitive request lines |
| ack | input | 1 | Acknowledge pulse input from the processor |
| int_req | output | 1 | Interrupt request to the processor |

## Verification
Each kind of internal fault shows up at the ports in its own way:

- **Stuck in-service bit:** `int_req` stays low after an end-of-interrupt while the line is still asserted. The bench checks this on the cycle right after the command write.
- **Wrong priority or offset:** the vector byte on the second pulse is wrong, or `rdata_oe` rises on the first pulse. Sweeps over every line, several bases including a wrapping one, every mask bit and every pair of lines expose both.
- **Initialization sequencer off by one byte:** the cascade read-back or the vector base comes back with another byte's value.
- **Missing or extra synchronizer stage:** `int_req` moves one clock early or late.

// File: rtl/vic_pkg.sv
package vic_pkg;

   typedef enum logic [2:0] {
      CFG_UNINIT,
      CFG_BASE,
      CFG_CASC,
      CFG_MODE,
      CFG_READY
   } cfg_state_e;

   typedef enum logic [1:0] {
      ACK_IDLE,
      ACK_FIRST,
      ACK_GAP,
      ACK_SECOND
   } ack_phase_e;

endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   if (STAGES < 2) begin : g_bad_stages
      $error("vic_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
   parameter int unsigned WIDTH = 8,
   localparam int unsigned IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
   input  logic [WIDTH-1:0] bits,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      idx = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (bits[i]) begin
            idx = IDX_W'(i);
         end
      end
   end

   assign valid = |bits;

endmodule

// File: rtl/vic_cfg.sv
module vic_cfg
   import vic_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned N_LINES  = 8,
   parameter int unsigned INIT_BIT = 4,
   parameter logic [DATA_W-1:0] EOI_CODE = DATA_W'(8'h20)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_cmd,
   input  logic               wr_data,
   input  logic [DATA_W-1:0]  wdata,
   output logic               ready,
   output logic [DATA_W-1:0]  base,
   output logic [DATA_W-1:0]  casc,
   output logic [N_LINES-1:0] mask,
   output logic               fast_vec,
   output logic               eoi,
   output logic               restart
);

   cfg_state_e state;
   logic       need_mode;

   if (INIT_BIT >= DATA_W) begin : g_bad_init_bit
      $error("vic_cfg: INIT_BIT outside the data width");
   end
   if (N_LINES > DATA_W) begin : g_bad_lines
      $error("vic_cfg: mask wider than the data port");
   end

   assign restart = wr_cmd && wdata[INIT_BIT];
   assign eoi     = wr_cmd && !wdata[INIT_BIT] && (wdata == EOI_CODE) && ready;
   assign ready   = (state == CFG_READY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= CFG_UNINIT;
         need_mode <= 1'b0;
         base      <= '0;
         casc      <= '0;
         mask      <= '1;
         fast_vec  <= 1'b0;
      end else if (restart) begin
         state     <= CFG_BASE;
         need_mode <= wdata[0];
         fast_vec  <= 1'b0;
         mask      <= '1;
      end else if (wr_data) begin
         case (state)
            CFG_BASE: begin
               base  <= wdata;
               state <= CFG_CASC;
            end
            CFG_CASC: begin
               casc  <= wdata;
               state <= need_mode ? CFG_MODE : CFG_READY;
            end
            CFG_MODE: begin
               fast_vec <= wdata[0];
               state    <= CFG_READY;
            end
            CFG_READY: begin
               mask <= wdata[N_LINES-1:0];
            end
            default: begin
               state <= state;
            end
         endcase
      end
   end

   // R2: configuration completes only on a data-port write
   a_r2_ready_after_data : assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !$past(ready)) |-> $past(wr_data));

endmodule

// File: rtl/vic_svc.sv
module vic_svc
   import vic_pkg::*;
#(
   parameter int unsigned N_LINES = 8,
   localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ready,
   input  logic [N_LINES-1:0] pend,
   input  logic               ack,
   input  logic               eoi,
   input  logic               restart,
   output logic               int_req,
   output logic               drive,
   output logic [IDX_W-1:0]   line
);

   ack_phase_e         phase;
   logic [N_LINES-1:0] isr;
   logic [N_LINES-1:0] isr_nxt;
   logic [N_LINES-1:0] allow;
   logic [N_LINES-1:0] cand;
   logic               cand_v;
   logic [IDX_W-1:0]   cand_idx;
   logic               top_v;
   logic [IDX_W-1:0]   top_idx;
   logic               grab;
   logic               grant_ok;

   // a line may be granted only if no line of equal or higher priority is in service
   for (genvar i = 0; i < N_LINES; i++) begin : g_allow
      assign allow[i] = ~|isr[i:0];
   end

   assign cand = pend & allow;

   vic_prio #(.WIDTH(N_LINES)) u_cand (
      .bits  (cand),
      .valid (cand_v),
      .idx   (cand_idx)
   );

   vic_prio #(.WIDTH(N_LINES)) u_top (
      .bits  (isr),
      .valid (top_v),
      .idx   (top_idx)
   );

   assign grant_ok = cand_v && ready;
   assign grab     = (phase == ACK_IDLE) && ack;
   assign int_req  = grant_ok && (phase == ACK_IDLE);
   assign drive    = ack && ((phase == ACK_GAP) || (phase == ACK_SECOND));

   always_comb begin
      isr_nxt = isr;
      if (restart) begin
         isr_nxt = '0;
      end else begin
         if (eoi && top_v) begin
            isr_nxt[top_idx] = 1'b0;
         end
         if (grab && grant_ok) begin
            isr_nxt[cand_idx] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= ACK_IDLE;
         isr   <= '0;
         line  <= '0;
      end else begin
         isr <= isr_nxt;
         case (phase)
            ACK_IDLE: begin
               if (ack) begin
                  phase <= ACK_FIRST;
                  line  <= grant_ok ? cand_idx : IDX_W'(N_LINES - 1);
               end
            end
            ACK_FIRST:  if (!ack) phase <= ACK_GAP;
            ACK_GAP:    if (ack)  phase <= ACK_SECOND;
            ACK_SECOND: if (!ack) phase <= ACK_IDLE;
            default:    phase <= ACK_IDLE;
         endcase
      end
   end

   // R7: an end-of-interrupt retires exactly one in-service line
   a_r7_eoi_retires_one : assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && top_v && !restart && !(grab && grant_ok))
      |=> ($countones(isr) + 1 == $countones($past(isr))));

   // R12: restart leaves nothing in service
   a_r12_restart_clears : assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (isr == '0));

endmodule

// File: rtl/prog_int_ctrl.sv
module prog_int_ctrl #(
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned INIT_BIT    = 4,
   parameter logic [DATA_W-1:0] EOI_CODE = DATA_W'(8'h20)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cs,
   input  logic               port_sel,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   output logic               rdata_oe,
   input  logic [N_LINES-1:0] irq_in,
   input  logic               ack,
   output logic               int_req
);

   localparam int unsigned IDX_W = (N_LINES > 1) ? $clog2(N_LINES) : 1;

   if (N_LINES < 2 || N_LINES > DATA_W) begin : g_bad_lines
      $error("prog_int_ctrl: N_LINES must lie between 2 and DATA_W");
   end

   logic               wr_cmd;
   logic               wr_data;
   logic               rd;
   logic [N_LINES-1:0] req_s;
   logic               ready;
   logic [DATA_W-1:0]  base;
   logic [DATA_W-1:0]  casc;
   logic [N_LINES-1:0] mask;
   logic               fast_vec;
   logic               eoi;
   logic               restart;
   logic               drive;
   logic               drive_out;
   logic [IDX_W-1:0]   line;

   assign wr_cmd  = cs && wr_en && !port_sel;
   assign wr_data = cs && wr_en && port_sel;
   assign rd      = cs && rd_en;

   vic_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_in),
      .q     (req_s)
   );

   vic_cfg #(
      .DATA_W   (DATA_W),
      .N_LINES  (N_LINES),
      .INIT_BIT (INIT_BIT),
      .EOI_CODE (EOI_CODE)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_cmd   (wr_cmd),
      .wr_data  (wr_data),
      .wdata    (wdata),
      .ready    (ready),
      .base     (base),
      .casc     (casc),
      .mask     (mask),
      .fast_vec (fast_vec),
      .eoi      (eoi),
      .restart  (restart)
   );

   vic_svc #(.N_LINES(N_LINES)) u_svc (
      .clk     (clk),
      .rst_n   (rst_n),
      .ready   (ready),
      .pend    (req_s & ~mask),
      .ack     (ack),
      .eoi     (eoi),
      .restart (restart),
      .int_req (int_req),
      .drive   (drive),
      .line    (line)
   );

   assign drive_out = drive && fast_vec;
   assign rdata_oe  = drive_out || rd;

   always_comb begin
      if (drive_out) begin
         rdata = base + DATA_W'(line);
      end else if (rd) begin
         rdata = port_sel ? DATA_W'(mask) : casc;
      end else begin
         rdata = '0;
      end
   end

   // R1: no request leaves the block before configuration
   a_r1_no_req_unconfigured : assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> !int_req);

   // R4: a request always has an unmasked synchronized line behind it
   a_r4_req_needs_unmasked : assert property (@(posedge clk) disable iff (!rst_n)
      int_req |-> |(req_s & ~mask));

   // R11: the bus is enabled only for reads or acknowledge
   a_r11_bus_enable : assert property (@(posedge clk) disable iff (!rst_n)
      rdata_oe |-> (rd || ack));

endmodule

// File: tb/test_prog_int_ctrl.sv
module test_prog_int_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cs = 1'b0;
   logic       port_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       rdata_oe;
   logic [7:0] irq_in = '0;
   logic       ack = 1'b0;
   logic       int_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   prog_int_ctrl i_prog_int_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cs       (cs),
      .port_sel (port_sel),
      .wr_en    (wr_en),
      .rd_en    (rd_en),
      .wdata    (wdata),
      .rdata    (rdata),
      .rdata_oe (rdata_oe),
      .irq_in   (irq_in),
      .ack      (ack),
      .int_req  (int_req)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic p, input logic [7:0] d);
      @(negedge clk);
      cs = 1'b1; port_sel = p; wr_en = 1'b1; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr_en = 1'b0;
   endtask

   task automatic rd(input logic p, output logic [7:0] d, output logic oe);
      @(negedge clk);
      cs = 1'b1; port_sel = p; rd_en = 1'b1;
      #1 d = rdata; oe = rdata_oe;
      @(negedge clk);
      cs = 1'b0; rd_en = 1'b0;
   endtask

   task automatic ackseq(output logic [7:0] v, output logic oe1, output logic oe2);
      @(negedge clk);
      ack = 1'b1;
      #1 oe1 = rdata_oe;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
      ack = 1'b1;
      #1 oe2 = rdata_oe; v = rdata;
      @(negedge clk);
      ack = 1'b0;
      @(negedge clk);
   endtask

   task automatic set_irq(input logic [7:0] v);
      @(negedge clk);
      irq_in = v;
      repeat (2) @(negedge clk);
   endtask

   task automatic init(input logic [7:0] b, input logic [7:0] c, input bit has4, input bit m);
      wr(1'b0, has4 ? 8'h11 : 8'h10);
      wr(1'b1, b);
      wr(1'b1, c);
      if (has4) wr(1'b1, {7'b0, m});
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      logic       oe, oe1, oe2;
      logic [7:0] v;
      logic [7:0] bases [3];
      bases[0] = 8'h20; bases[1] = 8'h48; bases[2] = 8'hFC;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(int_req == 1'b0, "R1 int_req after reset", int_req, 0);
      chk(rdata_oe == 1'b0, "R11 bus idle after reset", rdata_oe, 0);
      rd(1'b1, d, oe);
      chk(d == 8'hFF, "R1 reset mask", d, 8'hFF);
      chk(oe == 1'b1, "R11 bus enabled on read", oe, 1);
      set_irq(8'h01);
      @(negedge clk);
      chk(int_req == 1'b0, "R1 no request before init", int_req, 0);
      set_irq(8'h00);

      // R2 init and cascade readback, R4 mask after init
      init(8'h20, 8'h04, 1'b1, 1'b1);
      rd(1'b0, d, oe);
      chk(d == 8'h04, "R2 cascade readback", d, 8'h04);
      rd(1'b1, d, oe);
      chk(d == 8'hFF, "R4 mask all ones after init", d, 8'hFF);
      wr(1'b1, 8'h5A);
      rd(1'b1, d, oe);
      chk(d == 8'h5A, "R4 mask readback", d, 8'h5A);

      // R3 R10 R6 R7 sweep over bases and lines
      foreach (bases[k]) begin
         init(bases[k], 8'h02 + 8'(k), 1'b1, 1'b1);
         rd(1'b0, d, oe);
         chk(d == 8'h02 + 8'(k), "R2 cascade readback sweep", d, 8'h02 + 8'(k));
         wr(1'b1, 8'h00);
         for (int n = 0; n < 8; n++) begin
            @(negedge clk);
            irq_in = 8'(1 << n);
            @(negedge clk);
            chk(int_req == 1'b0, "R10 not after one edge", int_req, 0);
            @(negedge clk);
            chk(int_req == 1'b1, "R10 request after two edges", int_req, 1);
            ackseq(v, oe1, oe2);
            chk(oe1 == 1'b0, "R3 no drive on first pulse", oe1, 0);
            chk(oe2 == 1'b1, "R3 drive on second pulse", oe2, 1);
            chk(v == bases[k] + 8'(n), "R3 vector value", v, bases[k] + 8'(n));
            chk(int_req == 1'b0, "R6 serviced line blocked", int_req, 0);
            wr(1'b0, 8'h20);
            chk(int_req == 1'b1, "R7 eoi releases line", int_req, 1);
            set_irq(8'h00);
         end
      end

      // R4 mask sweep with base 0x20
      init(8'h20, 8'h04, 1'b1, 1'b1);
      for (int n = 0; n < 8; n++) begin
         wr(1'b1, 8'(1 << n));
         set_irq(8'(1 << n));
         chk(int_req == 1'b0, "R4 masked line silent", int_req, 0);
         set_irq(8'hFF);
         ackseq(v, oe1, oe2);
         chk(v == 8'h20 + ((n == 0) ? 8'd1 : 8'd0), "R4 lowest unmasked wins", v,
             8'h20 + ((n == 0) ? 8'd1 : 8'd0));
         wr(1'b0, 8'h20);
         set_irq(8'h00);
      end

      // R5 every pair of lines
      wr(1'b1, 8'h00);
      for (int i = 0; i < 8; i++) begin
         for (int j = i + 1; j < 8; j++) begin
            set_irq(8'((1 << i) | (1 << j)));
            ackseq(v, oe1, oe2);
            chk(v == 8'h20 + 8'(i), "R5 priority pair", v, 8'h20 + 8'(i));
            wr(1'b0, 8'h20);
            set_irq(8'h00);
         end
      end

      // R6 nesting and R7 ignored command
      set_irq(8'h10);
      ackseq(v, oe1, oe2);
      chk(v == 8'h24, "R6 first grant line 4", v, 8'h24);
      set_irq(8'h34);
      chk(int_req == 1'b1, "R6 higher line nests", int_req, 1);
      ackseq(v, oe1, oe2);
      chk(v == 8'h22, "R6 nested vector", v, 8'h22);
      chk(int_req == 1'b0, "R6 lower lines blocked", int_req, 0);
      wr(1'b0, 8'h0A);
      chk(int_req == 1'b0, "R7 other command ignored", int_req, 0);
      set_irq(8'h30);
      wr(1'b0, 8'h20);
      chk(int_req == 1'b0, "R7 eoi retires line 2 only", int_req, 0);
      wr(1'b0, 8'h20);
      chk(int_req == 1'b1, "R7 second eoi retires line 4", int_req, 1);
      ackseq(v, oe1, oe2);
      chk(v == 8'h24, "R7 line 4 again", v, 8'h24);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // R8 spurious vector
      set_irq(8'h08);
      chk(int_req == 1'b1, "R8 request seen", int_req, 1);
      set_irq(8'h00);
      @(negedge clk);
      chk(int_req == 1'b0, "R8 request withdrawn", int_req, 0);
      ackseq(v, oe1, oe2);
      chk(v == 8'h27, "R8 spurious vector", v, 8'h27);
      set_irq(8'h80);
      chk(int_req == 1'b1, "R8 nothing left in service", int_req, 1);
      ackseq(v, oe1, oe2);
      chk(v == 8'h27, "R8 real line 7", v, 8'h27);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // R12 restart clears service state
      set_irq(8'h08);
      ackseq(v, oe1, oe2);
      chk(int_req == 1'b0, "R12 line 3 in service", int_req, 0);
      wr(1'b0, 8'h11);
      chk(int_req == 1'b0, "R12 silent during init", int_req, 0);
      wr(1'b1, 8'h40);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'h01);
      wr(1'b1, 8'h00);
      chk(int_req == 1'b1, "R12 in-service cleared", int_req, 1);
      ackseq(v, oe1, oe2);
      chk(v == 8'h43, "R12 new base", v, 8'h43);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      // R9 modes
      init(8'h30, 8'h02, 1'b0, 1'b0);
      wr(1'b1, 8'h00);
      set_irq(8'h02);
      ackseq(v, oe1, oe2);
      chk(oe2 == 1'b0, "R9 no mode byte no drive", oe2, 0);
      wr(1'b0, 8'h20);
      set_irq(8'h00);
      init(8'h30, 8'h02, 1'b1, 1'b0);
      rd(1'b0, d, oe);
      chk(d == 8'h02, "R2 cascade readback secondary", d, 8'h02);
      wr(1'b1, 8'h00);
      set_irq(8'h02);
      ackseq(v, oe1, oe2);
      chk(oe2 == 1'b0, "R9 mode 0 no drive", oe2, 0);
      chk(rdata_oe == 1'b0, "R11 bus idle after ack", rdata_oe, 0);
      wr(1'b0, 8'h20);
      set_irq(8'h00);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule